// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Aligner

This block sits between a processor's register file and a 32-bit data memory port. For each memory request it forms the effective address from a base register and an optional offset. The offset is either a second register, which is added or subtracted, or a zero-extended 12-bit constant. The block then maps the access onto the four byte lanes of the bus. Word, halfword and byte transfers are supported in both directions.

Stores leave with per-lane write strobes and with the data replicated across the lanes, so the active lanes always carry the right bytes. Loads return a 32-bit value: a byte or halfword is taken from the proper lanes and zero-extended. A static input selects how byte addresses map onto lanes, either lowest address in the least-significant lane (little-endian) or lowest address in the most-significant lane (big-endian). A misaligned halfword or word raises a flag, and no strobe is driven for that request.

The request is registered once. Address, strobes, store data and the flag appear one cycle after the request. Memory read data is expected during that same output cycle and is steered combinationally onto the load result.

Top module: `lsa_top`

## Requirements
- R1: While `rstN` is low, `memValid`, `memWrite`, `memStrobe` and `misaligned` read zero.
- R2: All request outputs are registered one cycle after the request. A cycle with `reqValid` low yields `memValid`=0 and `memStrobe`=0 in the next cycle.
- R3: With `offMode`=0 (register indirect), `memAddr` equals `baseReg`.
- R4: With `offMode`=1, `memAddr` = `baseReg`+`indexReg`. With `offMode`=2, `memAddr` = `baseReg`-`indexReg`.
- R5: With `offMode`=3, `memAddr` = `baseReg` plus `immOff` zero-extended.
- R6: A byte store (`accSize`=0) with address bits 1:0 equal to k asserts the single strobe bit k in little-endian mode, or bit 3-k in big-endian mode. Strobe bit i covers data bits 8i+7:8i. `memWdata` carries `storeVal[7:0]` in all four lanes.
- R7: An aligned halfword store (`accSize`=1) asserts strobes 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1 in little-endian mode. In big-endian mode the two patterns are swapped. `memWdata` carries `storeVal[15:0]` in both halves.
- R8: An aligned word store (`accSize`=2, or the spare code 3) asserts strobes 4'b1111 and passes `storeVal` unchanged in both byte orders.
- R9: A halfword with address bit 0 set, or a word with address bits 1:0 nonzero, sets `misaligned` and drives `memStrobe`=0.
- R10: A load (`isStore`=0) gives `memWrite`=0 and `memStrobe`=0.
- R11: A byte load returns, zero-extended, the lane that R6 selects for the registered address.
- R12: A halfword load returns, zero-extended, the 16 bits from the lanes that R7 selects, most significant lane high. A word load returns `memRdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| isStore | input | 1 | 1 = store, 0 = load |
| accSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| offMode | input | 2 | 0 base only, 1 base+index, 2 base-index, 3 base+constant |
| baseReg | input | 32 | Base register value |
| indexReg | input | 32 | Index register value |
| immOff | input | 12 | Constant offset, zero-extended |
| storeVal | input | 32 | Store data, right-justified |
| bigEndian | input | 1 | Static byte order select |
| memRdata | input | 32 | Read data for the registered request |
| memValid | output | 1 | Registered request valid |
| memWrite | output | 1 | Registered request is a store |
| memAddr | output | 32 | Effective address |
| memStrobe | output | 4 | Per-lane write enables |
| memWdata | output | 32 | Lane-replicated store data |
| misaligned | output | 1 | Alignment violation flag |
| loadResult | output | 32 | Extracted, zero-extended load data |

## Verification
The assertions assume that the request inputs sampled at an edge describe the request whose results appear at the next edge. This holds because each input is changed only between edges, with a full cycle before sampling. They also assume that `bigEndian` does not change while a request is in flight. The stimulus sets it together with each request and keeps it there until the result has been read. The address assertions compare against the previous cycle's base and index ports. Because of this, the bench never changes those ports within the cycle whose result is being checked.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef struct packed {
    logic valid;
    logic store;
    logic useIndex;
    logic subIndex;
    logic useImm;
    logic isByte;
    logic isHalf;
    logic isWord;
  } lsCtrl_t;
endpackage

// File: rtl/lsa_ctrl.sv
module lsa_ctrl
  import lsa_pkg::*;
(
  input  logic       reqValid,
  input  logic       isStore,
  input  logic [1:0] accSize,
  input  logic [1:0] offMode,
  output lsCtrl_t    ctrl
);
  always_comb begin
    ctrl          = '0;
    ctrl.valid    = reqValid;
    ctrl.store    = reqValid & isStore;
    ctrl.useIndex = (offMode == 2'd1) || (offMode == 2'd2);
    ctrl.subIndex = (offMode == 2'd2);
    ctrl.useImm   = (offMode == 2'd3);
    ctrl.isByte   = (accSize == 2'd0);
    ctrl.isHalf   = (accSize == 2'd1);
    ctrl.isWord   = accSize[1];
  end
endmodule

// File: rtl/lsa_datapath.sv
module lsa_datapath
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [ADDR_W-1:0] indexReg,
  input  logic [IMM_W-1:0]  immOff,
  input  logic [BUS_W-1:0]  storeVal,
  input  logic              bigEndian,
  input  logic [BUS_W-1:0]  memRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memStrobe,
  output logic [BUS_W-1:0]  memWdata,
  output logic              misaligned,
  output logic [BUS_W-1:0]  loadResult
);
  localparam int PAD_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] offset, effAddr;
  logic [LANE_W-1:0] wordPos, lanePick;
  logic              halfSlot, misNow;
  logic [LANES-1:0]  laneMask;
  logic [BUS_W-1:0]  wdataNext;

  // held state for the load path
  logic [LANE_W-1:0] heldLane;
  logic              heldSlot, heldByte, heldHalf;

  always_comb begin
    if (ctrl.useIndex)    offset = indexReg;
    else if (ctrl.useImm) offset = {{PAD_W{1'b0}}, immOff};
    else                  offset = '0;
    effAddr  = ctrl.subIndex ? (baseReg - offset) : (baseReg + offset);
    wordPos  = effAddr[LANE_W-1:0];
    lanePick = bigEndian ? ~wordPos : wordPos;
    halfSlot = wordPos[LANE_W-1] ^ bigEndian;
    misNow   = (ctrl.isHalf & wordPos[0]) | (ctrl.isWord & (wordPos != '0));
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_comb begin
        if (ctrl.isByte)      laneMask[i] = (lanePick == LANE_W'(i));
        else if (ctrl.isHalf) laneMask[i] = ((i / 2) == int'(halfSlot));
        else                  laneMask[i] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    if (ctrl.isByte)      wdataNext = {LANES{storeVal[7:0]}};
    else if (ctrl.isHalf) wdataNext = {(LANES/2){storeVal[15:0]}};
    else                  wdataNext = storeVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memValid   <= 1'b0;
      memWrite   <= 1'b0;
      memAddr    <= '0;
      memStrobe  <= '0;
      memWdata   <= '0;
      misaligned <= 1'b0;
      heldLane   <= '0;
      heldSlot   <= 1'b0;
      heldByte   <= 1'b0;
      heldHalf   <= 1'b0;
    end else begin
      memValid   <= ctrl.valid;
      memWrite   <= ctrl.store;
      memAddr    <= effAddr;
      memStrobe  <= (ctrl.store && !misNow) ? laneMask : '0;
      memWdata   <= wdataNext;
      misaligned <= ctrl.valid & misNow;
      heldLane   <= lanePick;
      heldSlot   <= halfSlot;
      heldByte   <= ctrl.isByte;
      heldHalf   <= ctrl.isHalf;
    end
  end

  always_comb begin
    if (heldByte)
      loadResult = {{(BUS_W-8){1'b0}}, memRdata[{heldLane, 3'b000} +: 8]};
    else if (heldHalf)
      loadResult = {{(BUS_W-16){1'b0}}, memRdata[{heldSlot, 4'b0000} +: 16]};
    else
      loadResult = memRdata;
  end
endmodule

// File: rtl/lsa_top.sv
module lsa_top
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              isStore,
  input  logic [1:0]        accSize,
  input  logic [1:0]        offMode,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [ADDR_W-1:0] indexReg,
  input  logic [IMM_W-1:0]  immOff,
  input  logic [31:0]       storeVal,
  input  logic              bigEndian,
  input  logic [31:0]       memRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memStrobe,
  output logic [31:0]       memWdata,
  output logic              misaligned,
  output logic [31:0]       loadResult
);
  lsCtrl_t ctrl;

  lsa_ctrl u_ctrl (
    .reqValid(reqValid), .isStore(isStore), .accSize(accSize),
    .offMode(offMode), .ctrl(ctrl)
  );

  lsa_datapath #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .baseReg(baseReg), .indexReg(indexReg), .immOff(immOff),
    .storeVal(storeVal), .bigEndian(bigEndian), .memRdata(memRdata),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memStrobe(memStrobe), .memWdata(memWdata), .misaligned(misaligned),
    .loadResult(loadResult)
  );
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        offMode,
  input logic [ADDR_W-1:0] baseReg,
  input logic [ADDR_W-1:0] indexReg,
  input logic              memValid,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [3:0]        memStrobe,
  input logic              misaligned
);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqValid) |-> (!memValid && memStrobe == 4'b0000));

  a_r3_indirect_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && $past(offMode) == 2'd0) |-> (memAddr == $past(baseReg)));

  a_r4_index_sub_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && $past(offMode) == 2'd2) |->
      (memAddr == $past(baseReg) - $past(indexReg)));

  a_r6_strobe_shape: assert property (@(posedge clk) disable iff (!rstN)
    memStrobe == 4'b0000 || $countones(memStrobe) == 1 ||
    memStrobe == 4'b0011 || memStrobe == 4'b1100 || memStrobe == 4'b1111);

  a_r9_misaligned_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (memStrobe == 4'b0000));

  a_r10_load_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !memWrite |-> (memStrobe == 4'b0000));
endmodule

bind lsa_top lsa_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .offMode(offMode),
  .baseReg(baseReg), .indexReg(indexReg), .memValid(memValid),
  .memWrite(memWrite), .memAddr(memAddr), .memStrobe(memStrobe),
  .misaligned(misaligned)
);

// File: tb/tb_lsa_top.sv
module tb_lsa_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, isStore = 1'b0, bigEndian = 1'b0;
  logic [1:0]  accSize = '0, offMode = '0;
  logic [31:0] baseReg = '0, indexReg = '0, storeVal = '0, memRdata = '0;
  logic [11:0] immOff = '0;
  logic        memValid, memWrite, misaligned;
  logic [31:0] memAddr, memWdata, loadResult;
  logic [3:0]  memStrobe;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lsa_top dut (.*);

  typedef struct packed {
    logic [7:0]  rq;
    logic        st;
    logic [1:0]  sz;
    logic [1:0]  md;
    logic        be;
    logic [31:0] base;
    logic [31:0] idx;
    logic [11:0] imm;
    logic [31:0] sv;
    logic [31:0] rd;
    logic [31:0] eAddr;
    logic [3:0]  eStb;
    logic [31:0] eWd;
    logic        eMis;
    logic [31:0] eLd;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R6 byte store, little-endian lane 1
    '{8'd6, 1'b1, 2'd0, 2'd0, 1'b0, 32'h1000_0001, 32'h0, 12'h0, 32'h0000_00AB, 32'h0, 32'h1000_0001, 4'b0010, 32'hABAB_ABAB, 1'b0, 32'h0},
    // R6 byte store, big-endian -> lane 2
    '{8'd6, 1'b1, 2'd0, 2'd0, 1'b1, 32'h1000_0001, 32'h0, 12'h0, 32'h0000_00AB, 32'h0, 32'h1000_0001, 4'b0100, 32'hABAB_ABAB, 1'b0, 32'h0},
    // R7 / R4 halfword store, add index, little-endian upper half
    '{8'd7, 1'b1, 2'd1, 2'd1, 1'b0, 32'h1000_0000, 32'h2, 12'h0, 32'h0000_1234, 32'h0, 32'h1000_0002, 4'b1100, 32'h1234_1234, 1'b0, 32'h0},
    // R7 halfword store, big-endian lower half
    '{8'd7, 1'b1, 2'd1, 2'd1, 1'b1, 32'h1000_0000, 32'h2, 12'h0, 32'h0000_1234, 32'h0, 32'h1000_0002, 4'b0011, 32'h1234_1234, 1'b0, 32'h0},
    // R5 / R8 word store, constant offset 4
    '{8'd5, 1'b1, 2'd2, 2'd3, 1'b0, 32'h1000_0000, 32'h0, 12'h004, 32'hDEAD_BEEF, 32'h0, 32'h1000_0004, 4'b1111, 32'hDEAD_BEEF, 1'b0, 32'h0},
    // R4 / R8 word store, subtract index, big-endian
    '{8'd4, 1'b1, 2'd2, 2'd2, 1'b1, 32'h1000_0010, 32'h8, 12'h0, 32'hCAFE_F00D, 32'h0, 32'h1000_0008, 4'b1111, 32'hCAFE_F00D, 1'b0, 32'h0},
    // R9 misaligned halfword store
    '{8'd9, 1'b1, 2'd1, 2'd0, 1'b0, 32'h1000_0003, 32'h0, 12'h0, 32'h0000_5678, 32'h0, 32'h1000_0003, 4'b0000, 32'h5678_5678, 1'b1, 32'h0},
    // R9 misaligned word store via constant 2
    '{8'd9, 1'b1, 2'd2, 2'd3, 1'b0, 32'h1000_0000, 32'h0, 12'h002, 32'h1111_1111, 32'h0, 32'h1000_0002, 4'b0000, 32'h1111_1111, 1'b1, 32'h0},
    // R11 byte load little-endian lane 3
    '{8'd11, 1'b0, 2'd0, 2'd0, 1'b0, 32'h1000_0003, 32'h0, 12'h0, 32'h0, 32'h1122_3344, 32'h1000_0003, 4'b0000, 32'h0, 1'b0, 32'h0000_0011},
    // R11 byte load big-endian lane 0
    '{8'd11, 1'b0, 2'd0, 2'd0, 1'b1, 32'h1000_0003, 32'h0, 12'h0, 32'h0, 32'h1122_3344, 32'h1000_0003, 4'b0000, 32'h0, 1'b0, 32'h0000_0044},
    // R12 halfword load little-endian upper half
    '{8'd12, 1'b0, 2'd1, 2'd0, 1'b0, 32'h1000_0002, 32'h0, 12'h0, 32'h0, 32'hA1B2_C3D4, 32'h1000_0002, 4'b0000, 32'h0, 1'b0, 32'h0000_A1B2},
    // R12 halfword load big-endian lower half
    '{8'd12, 1'b0, 2'd1, 2'd0, 1'b1, 32'h1000_0002, 32'h0, 12'h0, 32'h0, 32'hA1B2_C3D4, 32'h1000_0002, 4'b0000, 32'h0, 1'b0, 32'h0000_C3D4},
    // R12 / R10 word load, subtract index
    '{8'd12, 1'b0, 2'd2, 2'd2, 1'b1, 32'h1000_0004, 32'h4, 12'h0, 32'h0, 32'h89AB_CDEF, 32'h1000_0000, 4'b0000, 32'h0, 1'b0, 32'h89AB_CDEF},
    // R8 spare size code acts as word, R3 register indirect
    '{8'd8, 1'b1, 2'd3, 2'd0, 1'b0, 32'h1000_0008, 32'h0, 12'h0, 32'h0102_0304, 32'h0, 32'h1000_0008, 4'b1111, 32'h0102_0304, 1'b0, 32'h0},
    // R6 byte store big-endian, constant 3 -> lane 0
    '{8'd6, 1'b1, 2'd0, 2'd3, 1'b1, 32'h1000_0000, 32'h0, 12'h003, 32'h0000_00C5, 32'h0, 32'h1000_0003, 4'b0001, 32'hC5C5_C5C5, 1'b0, 32'h0},
    // R9 misaligned halfword load
    '{8'd9, 1'b0, 2'd1, 2'd0, 1'b0, 32'h1000_0001, 32'h0, 12'h0, 32'h0, 32'h0, 32'h1000_0001, 4'b0000, 32'h0, 1'b1, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 memValid in reset", {31'b0, memValid}, 32'd0);
    chk("R1 memStrobe in reset", {28'b0, memStrobe}, 32'd0);
    chk("R1 misaligned in reset", {31'b0, misaligned}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      v = VECS[i];
      @(negedge clk);
      reqValid = 1'b1; isStore = v.st; accSize = v.sz; offMode = v.md;
      bigEndian = v.be; baseReg = v.base; indexReg = v.idx; immOff = v.imm;
      storeVal = v.sv;
      @(negedge clk);
      reqValid = 1'b0;
      memRdata = v.rd;
      #1;
      tg = $sformatf("R%0d vec%0d", v.rq, i);
      chk({tg, " valid"}, {31'b0, memValid}, 32'd1);
      chk({tg, " write"}, {31'b0, memWrite}, {31'b0, v.st});
      chk({tg, " addr"}, memAddr, v.eAddr);
      chk({tg, " strobe"}, {28'b0, memStrobe}, {28'b0, v.eStb});
      chk({tg, " misaligned"}, {31'b0, misaligned}, {31'b0, v.eMis});
      if (v.st) chk({tg, " wdata"}, memWdata, v.eWd);
      else if (!v.eMis) chk({tg, " load"}, loadResult, v.eLd);
    end

    // R2: idle cycle produces no access
    @(negedge clk);
    chk("R2 idle memValid", {31'b0, memValid}, 32'd0);
    chk("R2 idle memStrobe", {28'b0, memStrobe}, 32'd0);

    // R10: aligned word load drives no strobes even in little-endian
    reqValid = 1'b1; isStore = 1'b0; accSize = 2'd2; offMode = 2'd0;
    bigEndian = 1'b0; baseReg = 32'h2000_0000;
    @(negedge clk);
    reqValid = 1'b0;
    memRdata = 32'h5555_AAAA;
    #1;
    chk("R10 load write", {31'b0, memWrite}, 32'd0);
    chk("R10 load strobe", {28'b0, memStrobe}, 32'd0);
    chk("R12 word load LE", loadResult, 32'h5555_AAAA);

    // R1: reset applied with a request pending clears the outputs
    @(negedge clk);
    reqValid = 1'b1; isStore = 1'b1; accSize = 2'd2; storeVal = 32'h0F0F_0F0F;
    rstN = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 mid-run memValid", {31'b0, memValid}, 32'd0);
    chk("R1 mid-run memWrite", {31'b0, memWrite}, 32'd0);
    chk("R1 mid-run memStrobe", {28'b0, memStrobe}, 32'd0);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    finish_run();
  end
endmodule